// File: doc/BRIEF.md
# Buck Converter Startup Sequencer

This block owns the power-up, enable and shutdown order of a synchronous buck controller. The analog parts are outside the block: the undervoltage comparator, the current-limit programming engine, the overcurrent latch, the two compensation-node comparators (about 0.4 V and about 0.9 V) and the feedback-versus-reference comparator. Each reaches the block as a one-bit flag. From these flags the sequencer decides when the soft-start current source charges the compensation node, when the PWM logic runs, when the switch node leaves tri-state and when the loop changes from open to closed.

The compensation node has two jobs. It is the soft-start ramp, and it is also an enable pin: an external device that pulls it below the lower threshold parks the converter with the low-side switch held on. An undervoltage trip always returns the block to its power-off state. An overcurrent latch moves it to a fault state that only the power-on reset input clears. Every input flag passes through a two-flop synchroniser. The three analog threshold flags are also debounced for a parameterised number of clocks.

Top module: `buck_seq_top`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it is released, `state` is OFF. In OFF, `swTristate`=1, `ssDischarge`=1 and every other drive output is 0.
- R2: In OFF, a synchronised `uvloOk`=1 moves the block to PROGRAM. PROGRAM drives only `swTristate`=1. It stays in PROGRAM until `progDone`=1, and then moves to SS_DELAY, where `ssSrcEn`=1 and the switch node stays tri-stated.
- R3: In SS_DELAY, a debounced `compAboveLo`=1 moves the block to ENABLED_IDLE. ENABLED_IDLE has `pwmEn`=1 and `ssSrcEn`=1, but the switch node stays tri-stated and both gate enables are 0.
- R4: In ENABLED_IDLE, a debounced `compAboveHi`=1 moves the block to OPEN_LOOP. OPEN_LOOP has `swTristate`=0, `hsGateEn`=`lsGateEn`=1, `pwmEn`=1, `ssSrcEn`=1 and `closedLoop`=0.
- R5: In OPEN_LOOP, a debounced `fbAtRef`=1 moves the block to CLOSED_LOOP. CLOSED_LOOP has `closedLoop`=1 and `ssSrcEn`=0, and otherwise drives like OPEN_LOOP. If `fbAtRef` later drops, the block stays in CLOSED_LOOP.
- R6: In ENABLED_IDLE, OPEN_LOOP or CLOSED_LOOP, a debounced `compAboveLo`=0 moves the block to DISABLED. DISABLED has `pwmEn`=0, `hsGateEn`=0, `lsGateEn`=1, `swTristate`=0 and `ssSrcEn`=1. When `compAboveLo` returns to 1, the block goes back to ENABLED_IDLE.
- R7: From any state other than FAULT, `uvloOk`=0 reaches OFF exactly three clock edges after it is first sampled low.
- R8: A synchronised `ocFault`=1, while `uvloOk` is high, moves any state to FAULT. FAULT has `swTristate`=1, `ssDischarge`=1 and every other drive output 0. Only `rstN` low leaves FAULT; undervoltage trips and input changes do not.
- R9: A pulse on a compensation or feedback flag that lasts fewer than DEB_CYCLES clocks has no effect on `state`. A pulse of DEB_CYCLES clocks or more is accepted.
- R10: `state` encodes OFF=0, PROGRAM=1, SS_DELAY=2, ENABLED_IDLE=3, OPEN_LOOP=4, CLOSED_LOOP=5, DISABLED=6, FAULT=7.
- R11: In OPEN_LOOP or CLOSED_LOOP, a debounced `compAboveHi`=0 with `compAboveLo` still 1 moves the block to ENABLED_IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rstN | input | 1 | Active-low power-on reset; the only way out of FAULT |
| uvloOk | input | 1 | Supply is above the undervoltage threshold |
| progDone | input | 1 | Current-limit programming has finished |
| ocFault | input | 1 | Overcurrent trip counter has latched |
| compAboveLo | input | 1 | Compensation node is above the lower (about 0.4 V) threshold |
| compAboveHi | input | 1 | Compensation node is above the upper (about 0.9 V) threshold |
| fbAtRef | input | 1 | Feedback has reached the reference |
| swTristate | output | 1 | Holds the switch node in high impedance |
| hsGateEn | output | 1 | Lets the PWM drive the high-side gate |
| lsGateEn | output | 1 | Lets the low-side gate turn on |
| pwmEn | output | 1 | Enables the PWM logic |
| ssSrcEn | output | 1 | Turns on the soft-start current source into the compensation node |
| ssDischarge | output | 1 | Discharges the soft-start node |
| closedLoop | output | 1 | 1 in closed-loop regulation, 0 in open loop |
| state | output | 3 | Sequencer state code (see R10) |

## Verification
The startup path is walked forward one flag at a time. This shows that each threshold moves the sequence exactly one step, and that the feedback flag is ignored after closed loop is reached. An undervoltage drop and an overcurrent latch are each applied from every state a reset can lead to. The undervoltage drop is sampled at the exact edge, to separate the three-edge exit from a slower or a faster one. The overcurrent case shows that the fault state survives later undervoltage trips. A pulse-width sweep on the lower compensation flag, from one clock to one more than the debounce length, places the accept/reject boundary at DEB_CYCLES.

// File: rtl/buck_seq_pkg.sv
package buck_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF       = 3'd0,
    ST_PROGRAM   = 3'd1,
    ST_SS_DELAY  = 3'd2,
    ST_EN_IDLE   = 3'd3,
    ST_OPEN      = 3'd4,
    ST_CLOSED    = 3'd5,
    ST_DISABLED  = 3'd6,
    ST_FAULT     = 3'd7
  } seqState_e;

  // Flag order inside the raw/clean vectors
  localparam int FLAG_UVLO  = 0;
  localparam int FLAG_PROG  = 1;
  localparam int FLAG_OC    = 2;
  localparam int FLAG_CLO   = 3;
  localparam int FLAG_CHI   = 4;
  localparam int FLAG_FB    = 5;
  localparam int NUM_FLAGS  = 6;

  // Flags that receive the debounce filter (analog thresholds)
  localparam logic [NUM_FLAGS-1:0] DEB_MASK = 6'b111000;

  typedef struct packed {
    logic uvloOk;
    logic progDone;
    logic ocFault;
    logic compLo;
    logic compHi;
    logic fbRef;
  } seqFlags_t;

  typedef struct packed {
    logic swTristate;
    logic hsGateEn;
    logic lsGateEn;
    logic pwmEn;
    logic ssSrcEn;
    logic ssDischarge;
    logic closedLoop;
  } seqDrive_t;

endpackage

// File: rtl/buck_seq_filter.sv
module buck_seq_filter
  import buck_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DEB_CYCLES  = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_FLAGS-1:0] rawIn,
  output seqFlags_t            flags
);

  localparam int CW = (DEB_CYCLES < 2) ? 1 : $clog2(DEB_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(DEB_CYCLES - 1);

  logic [NUM_FLAGS-1:0] cleanVec;

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    logic [SYNC_STAGES-1:0] chain;
    logic                   syncBit;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[SYNC_STAGES-2:0], rawIn[i]};
    end
    assign syncBit = chain[SYNC_STAGES-1];

    if (DEB_MASK[i]) begin : g_deb
      logic [CW-1:0] cnt;
      logic          held;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          cnt  <= '0;
          held <= 1'b0;
        end else if (syncBit == held) begin
          cnt <= '0;
        end else if (cnt == CNT_LAST) begin
          cnt  <= '0;
          held <= syncBit;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
      assign cleanVec[i] = held;
    end else begin : g_pass
      assign cleanVec[i] = syncBit;
    end
  end

  assign flags.uvloOk   = cleanVec[FLAG_UVLO];
  assign flags.progDone = cleanVec[FLAG_PROG];
  assign flags.ocFault  = cleanVec[FLAG_OC];
  assign flags.compLo   = cleanVec[FLAG_CLO];
  assign flags.compHi   = cleanVec[FLAG_CHI];
  assign flags.fbRef    = cleanVec[FLAG_FB];

endmodule

// File: rtl/buck_seq_ctrl.sv
module buck_seq_ctrl
  import buck_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  seqFlags_t flags,
  output seqState_e curState,
  output seqDrive_t drive
);

  seqState_e nextState;

  always_comb begin
    nextState = curState;
    if (curState == ST_FAULT) begin
      nextState = ST_FAULT;
    end else if (!flags.uvloOk) begin
      nextState = ST_OFF;
    end else if (flags.ocFault) begin
      nextState = ST_FAULT;
    end else begin
      unique case (curState)
        ST_OFF:      nextState = ST_PROGRAM;
        ST_PROGRAM:  if (flags.progDone) nextState = ST_SS_DELAY;
        ST_SS_DELAY: if (flags.compLo)   nextState = ST_EN_IDLE;
        ST_EN_IDLE: begin
          if (!flags.compLo)     nextState = ST_DISABLED;
          else if (flags.compHi) nextState = ST_OPEN;
        end
        ST_OPEN: begin
          if (!flags.compLo)      nextState = ST_DISABLED;
          else if (!flags.compHi) nextState = ST_EN_IDLE;
          else if (flags.fbRef)   nextState = ST_CLOSED;
        end
        ST_CLOSED: begin
          if (!flags.compLo)      nextState = ST_DISABLED;
          else if (!flags.compHi) nextState = ST_EN_IDLE;
        end
        ST_DISABLED: if (flags.compLo) nextState = ST_EN_IDLE;
        default:     nextState = ST_FAULT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curState <= ST_OFF;
    else       curState <= nextState;
  end

  always_comb begin
    drive = '0;
    unique case (curState)
      ST_OFF:      begin drive.swTristate = 1'b1; drive.ssDischarge = 1'b1; end
      ST_PROGRAM:  drive.swTristate = 1'b1;
      ST_SS_DELAY: begin drive.swTristate = 1'b1; drive.ssSrcEn = 1'b1; end
      ST_EN_IDLE:  begin
        drive.swTristate = 1'b1; drive.pwmEn = 1'b1; drive.ssSrcEn = 1'b1;
      end
      ST_OPEN: begin
        drive.hsGateEn = 1'b1; drive.lsGateEn = 1'b1;
        drive.pwmEn    = 1'b1; drive.ssSrcEn  = 1'b1;
      end
      ST_CLOSED: begin
        drive.hsGateEn = 1'b1; drive.lsGateEn   = 1'b1;
        drive.pwmEn    = 1'b1; drive.closedLoop = 1'b1;
      end
      ST_DISABLED: begin drive.lsGateEn = 1'b1; drive.ssSrcEn = 1'b1; end
      default:     begin drive.swTristate = 1'b1; drive.ssDischarge = 1'b1; end
    endcase
  end

endmodule

// File: rtl/buck_seq_top.sv
module buck_seq_top
  import buck_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DEB_CYCLES  = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       uvloOk,
  input  logic       progDone,
  input  logic       ocFault,
  input  logic       compAboveLo,
  input  logic       compAboveHi,
  input  logic       fbAtRef,
  output logic       swTristate,
  output logic       hsGateEn,
  output logic       lsGateEn,
  output logic       pwmEn,
  output logic       ssSrcEn,
  output logic       ssDischarge,
  output logic       closedLoop,
  output logic [2:0] state
);

  logic [NUM_FLAGS-1:0] rawVec;
  seqFlags_t            flags;
  seqState_e            curState;
  seqDrive_t            drive;

  always_comb begin
    rawVec            = '0;
    rawVec[FLAG_UVLO] = uvloOk;
    rawVec[FLAG_PROG] = progDone;
    rawVec[FLAG_OC]   = ocFault;
    rawVec[FLAG_CLO]  = compAboveLo;
    rawVec[FLAG_CHI]  = compAboveHi;
    rawVec[FLAG_FB]   = fbAtRef;
  end

  buck_seq_filter #(
    .SYNC_STAGES(SYNC_STAGES),
    .DEB_CYCLES (DEB_CYCLES)
  ) u_filter (
    .clk  (clk),
    .rstN (rstN),
    .rawIn(rawVec),
    .flags(flags)
  );

  buck_seq_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .flags   (flags),
    .curState(curState),
    .drive   (drive)
  );

  assign swTristate  = drive.swTristate;
  assign hsGateEn    = drive.hsGateEn;
  assign lsGateEn    = drive.lsGateEn;
  assign pwmEn       = drive.pwmEn;
  assign ssSrcEn     = drive.ssSrcEn;
  assign ssDischarge = drive.ssDischarge;
  assign closedLoop  = drive.closedLoop;
  assign state       = curState;

endmodule

// File: rtl/buck_seq_chk.sv
module buck_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       uvloOk,
  input logic       swTristate,
  input logic       hsGateEn,
  input logic       lsGateEn,
  input logic       pwmEn,
  input logic       ssDischarge,
  input logic [2:0] state
);

  AST_OFF_SAFE: assert property (@(posedge clk) disable iff (!rstN)
    (state == 3'd0) |-> (swTristate && !hsGateEn && !lsGateEn && ssDischarge)); // R1

  AST_SS_AFTER_PROG: assert property (@(posedge clk) disable iff (!rstN)
    (state == 3'd2) |-> ($past(state) == 3'd1 || $past(state) == 3'd2)); // R2

  AST_NO_SWITCH_PRE_HI: assert property (@(posedge clk) disable iff (!rstN)
    (state == 3'd3) |-> (swTristate && !hsGateEn && !lsGateEn && pwmEn)); // R3

  AST_DISABLED_LOW_ON: assert property (@(posedge clk) disable iff (!rstN)
    (state == 3'd6) |-> (!hsGateEn && lsGateEn && !pwmEn && !swTristate)); // R6

  AST_UVLO_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!uvloOk, 1) && $past(!uvloOk, 2) && $past(!uvloOk, 3))
      |-> (state == 3'd0 || state == 3'd7)); // R7

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ($past(state) == 3'd7) |-> (state == 3'd7)); // R8

  AST_NO_HS_TRISTATE: assert property (@(posedge clk) disable iff (!rstN)
    !(hsGateEn && swTristate)); // R4

endmodule

bind buck_seq_top buck_seq_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .uvloOk     (uvloOk),
  .swTristate (swTristate),
  .hsGateEn   (hsGateEn),
  .lsGateEn   (lsGateEn),
  .pwmEn      (pwmEn),
  .ssDischarge(ssDischarge),
  .state      (state)
);

// File: tb/buck_seq_top_test.sv
`timescale 1ns/1ps
module buck_seq_top_test;

  localparam int DEB    = 4;
  localparam int SETTLE = DEB + 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic uvloOk = 1'b0, progDone = 1'b0, ocFault = 1'b0;
  logic compAboveLo = 1'b0, compAboveHi = 1'b0, fbAtRef = 1'b0;
  logic swTristate, hsGateEn, lsGateEn, pwmEn, ssSrcEn, ssDischarge, closedLoop;
  logic [2:0] state;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  buck_seq_top #(.SYNC_STAGES(2), .DEB_CYCLES(DEB)) uut (
    .clk(clk), .rstN(rstN), .uvloOk(uvloOk), .progDone(progDone), .ocFault(ocFault),
    .compAboveLo(compAboveLo), .compAboveHi(compAboveHi), .fbAtRef(fbAtRef),
    .swTristate(swTristate), .hsGateEn(hsGateEn), .lsGateEn(lsGateEn), .pwmEn(pwmEn),
    .ssSrcEn(ssSrcEn), .ssDischarge(ssDischarge), .closedLoop(closedLoop), .state(state)
  );

  // {tri,hs,ls,pwm,src,dis,closed} expected per state code from the requirements
  function automatic logic [6:0] expDrive(input logic [2:0] s);
    case (s)
      3'd0: return 7'b1000010;
      3'd1: return 7'b1000000;
      3'd2: return 7'b1000100;
      3'd3: return 7'b1001100;
      3'd4: return 7'b0111100;
      3'd5: return 7'b0111001;
      3'd6: return 7'b0010100;
      default: return 7'b1000010;
    endcase
  endfunction

  task automatic checkState(input logic [2:0] exp, input string tag);
    logic [6:0] act;
    act = {swTristate, hsGateEn, lsGateEn, pwmEn, ssSrcEn, ssDischarge, closedLoop};
    total++;
    if (state !== exp || act !== expDrive(exp)) begin
      bad++;
      $display("FAIL %s: state=%0d drive=%b expected state=%0d drive=%b",
               tag, state, act, exp, expDrive(exp));
    end
  endtask

  task automatic settle();
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    {uvloOk, progDone, ocFault, compAboveLo, compAboveHi, fbAtRef} = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic reach(input int s);
    doReset();
    if (s >= 1) begin uvloOk = 1'b1; settle(); end
    if (s >= 2) begin progDone = 1'b1; settle(); end
    if (s >= 3) begin compAboveLo = 1'b1; settle(); end
    if (s >= 4) begin compAboveHi = 1'b1; settle(); end
    if (s == 5) begin fbAtRef = 1'b1; settle(); end
    if (s == 6) begin compAboveLo = 1'b0; compAboveHi = 1'b0; settle(); end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    // R1 R10: reset state
    repeat (2) @(negedge clk);
    checkState(3'd0, "R1 during reset");
    rstN = 1'b1;
    @(negedge clk);
    checkState(3'd0, "R1 R10 after release");

    // R2
    uvloOk = 1'b1; settle();
    checkState(3'd1, "R2 program");
    settle();
    checkState(3'd1, "R2 waits for progDone");
    progDone = 1'b1; settle();
    checkState(3'd2, "R2 soft-start delay");
    // R3, R4, R5
    compAboveLo = 1'b1; settle();
    checkState(3'd3, "R3 enabled idle");
    compAboveHi = 1'b1; settle();
    checkState(3'd4, "R4 open loop");
    fbAtRef = 1'b1; settle();
    checkState(3'd5, "R5 closed loop");
    fbAtRef = 1'b0; settle();
    checkState(3'd5, "R5 fb drop ignored");
    // R11
    compAboveHi = 1'b0; settle();
    checkState(3'd3, "R11 hi drop from closed");
    compAboveHi = 1'b1; settle();
    checkState(3'd4, "R4 re-entry open");
    compAboveHi = 1'b0; settle();
    checkState(3'd3, "R11 hi drop from open");
    // R6
    compAboveLo = 1'b0; settle();
    checkState(3'd6, "R6 disabled");
    compAboveLo = 1'b1; settle();
    checkState(3'd3, "R6 re-enable");

    // R7: undervoltage from every reachable non-fault state, exact edge
    for (int s = 1; s <= 6; s++) begin
      reach(s);
      checkState(3'(s), "R7 setup");
      uvloOk = 1'b0;
      repeat (2) @(negedge clk);
      checkState(3'(s), "R7 not before third edge");
      @(negedge clk);
      checkState(3'd0, "R7 off at third edge");
    end

    // R8: fault from every state, sticky until reset
    for (int s = 1; s <= 6; s++) begin
      reach(s);
      ocFault = 1'b1; settle();
      checkState(3'd7, "R8 enter fault");
      ocFault = 1'b0; compAboveLo = 1'b1; compAboveHi = 1'b1; uvloOk = 1'b0; settle();
      checkState(3'd7, "R8 fault survives uvlo");
      uvloOk = 1'b1; settle();
      checkState(3'd7, "R8 fault survives uvlo return");
    end
    doReset(); @(negedge clk);
    checkState(3'd0, "R8 reset clears fault");

    // R9: pulse-width sweep on the lower compensation flag
    for (int len = 1; len <= DEB + 1; len++) begin
      reach(2);
      compAboveLo = 1'b1;
      repeat (len) @(negedge clk);
      compAboveLo = 1'b0;
      settle(); settle();
      checkState((len >= DEB) ? 3'd6 : 3'd2, "R9 debounce width");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule